// File: doc/BRIEF.md
# Infrared Serial Pulse Encoder and Decoder

This block sits between a UART's serial bit streams and an infrared transceiver. On the transmit side it watches the UART's outgoing bit stream. For every zero bit it emits one short light pulse near the middle of the bit. One bits produce no light. On the receive side it synchronises the transceiver's pulse output and filters out glitches. Each accepted pulse becomes a zero level on the recovered bit stream that goes back to the UART receiver.

Two pulse widths are available. The normal width is three sixteenths of a bit, counted on the UART's 16x baud tick. The low-power width is three periods of a separate reference tick, whatever the bit rate. The encoder runs only while both the UART enable and the infrared enable are set. In that state the wired transmit line is parked at its idle high level and the wired receive line is ignored. In every other state the block is transparent: the wired lines pass straight through and the light output stays dark. A test loopback sends the encoder's pulses into the decoder in place of the external receiver and keeps the light output dark.

Top module: `sir_codec`

## Requirements
- R1: In normal-width mode (lp_mode = 0), each zero bit on txd_in gives exactly one ir_tx pulse, 3 baud ticks wide and starting 7 ticks (±1) after the bit boundary. A one bit gives no pulse. ir_tx = 1 means light.
- R2: In low-power mode (lp_mode = 1), each zero bit gives exactly one ir_tx pulse, exactly 3 lp_tick periods wide. It starts at the first lp_tick on or after tick 7 of the bit.
- R3: When uart_en = 0 or sir_en = 0, ir_tx stays 0, wired_txd equals txd_in, rx_bit equals wired_rxd, and pulses on ir_rx have no effect.
- R4: When uart_en = 1 and sir_en = 1, wired_txd stays 1 and wired_rxd has no effect on rx_bit.
- R5: When loop_en = 1 and test_mode = 1, ir_tx stays 0 and the encoder's pulses drive the decoder instead of ir_rx. loop_en alone does not change ir_tx.
- R6: ir_rx passes through a two-flop synchroniser. A pulse that stays high across two consecutive reference ticks drives rx_bit to 0 for 16 baud ticks from the moment it is accepted. A further accepted pulse restarts the 16-tick hold, so zero bits in a row give one continuous low.
- R7: A pulse on ir_rx shorter than one reference-tick period leaves rx_bit at 1.
- R8: The reference tick for pulse acceptance is baud16_tick in normal-width mode and lp_tick in low-power mode. With no lp_tick, no pulse is accepted in low-power mode.
- R9: After reset with both enables set, ir_tx = 0, rx_bit = 1 and wired_txd = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uart_en | input | 1 | Global UART enable; the block is transparent while 0 |
| sir_en | input | 1 | Infrared mode enable |
| lp_mode | input | 1 | Selects the low-power pulse width and the lp_tick acceptance reference |
| loop_en | input | 1 | Loopback request |
| test_mode | input | 1 | Test mode; together with loop_en it closes the loopback |
| baud16_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| lp_tick | input | 1 | One-cycle strobe of the independent low-power reference |
| txd_in | input | 1 | UART transmit bit stream |
| wired_rxd | input | 1 | Wired receive line |
| ir_rx | input | 1 | Transceiver output, 1 while light is seen |
| ir_tx | output | 1 | Transceiver drive, 1 for light |
| rx_bit | output | 1 | Recovered bit stream for the UART receiver |
| wired_txd | output | 1 | Wired transmit line |

## Verification
The bench aligns every bit to its own tick generator. In normal mode the transmit pulse rises two clocks after the tick that brings the bit counter to 7, and it lasts exactly 12 clocks at 4 clocks per tick. The bench checks the start in a one-tick window and checks the width exactly. A received pulse takes two clocks of synchronisation and then two reference ticks before rx_bit falls. The bench therefore checks rx_bit well after the latest acceptance point, and again well before or after the end of the 16-tick hold. The disabled, marking and loopback cases are sampled on every clock of the bit, and the rejected glitches are sampled across the whole window.

// File: rtl/sir_codec.sv
module sir_codec #(
  parameter int TICKS_PER_BIT  = 16,
  parameter int PULSE_START    = 7,
  parameter int PULSE_TICKS    = 3,
  parameter int LP_PULSE_TICKS = 3,
  parameter int HOLD_TICKS     = 16,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uart_en,
  input  logic sir_en,
  input  logic lp_mode,
  input  logic loop_en,
  input  logic test_mode,
  input  logic baud16_tick,
  input  logic lp_tick,
  input  logic txd_in,
  input  logic wired_rxd,
  input  logic ir_rx,
  output logic ir_tx,
  output logic rx_bit,
  output logic wired_txd
);
  localparam int CW  = $clog2(TICKS_PER_BIT);
  localparam int LPW = $clog2(LP_PULSE_TICKS + 1);
  localparam int HW  = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0]  LAST  = CW'(TICKS_PER_BIT - 1);
  localparam logic [CW-1:0]  WIN_LO = CW'(PULSE_START);
  localparam logic [CW-1:0]  WIN_HI = CW'(PULSE_START + PULSE_TICKS - 1);
  localparam logic [CW-1:0]  TRIG  = CW'(PULSE_START - 1);
  localparam logic [LPW-1:0] LP_END = LPW'(LP_PULSE_TICKS - 1);
  localparam logic [HW-1:0]  HOLD  = HW'(HOLD_TICKS);

  logic active, loop_mode;
  assign active    = uart_en & sir_en;
  assign loop_mode = loop_en & test_mode;

  // transmit bit framing
  logic          txd_q, bit_edge;
  logic [CW-1:0] bit_cnt;
  assign bit_edge = txd_in ^ txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q   <= 1'b1;
      bit_cnt <= '0;
    end else if (!active) begin
      txd_q   <= txd_in;
      bit_cnt <= '0;
    end else begin
      txd_q <= txd_in;
      if (bit_edge)
        bit_cnt <= '0;
      else if (baud16_tick)
        bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + CW'(1);
    end
  end

  // normal-width pulse
  logic std_on;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) std_on <= 1'b0;
    else        std_on <= active && !lp_mode && !txd_in && !bit_edge &&
                          bit_cnt >= WIN_LO && bit_cnt <= WIN_HI;
  end

  // low-power pulse, aligned to the reference tick
  logic           lp_pend, lp_on, lp_trig;
  logic [LPW-1:0] lp_cnt;
  assign lp_trig = active && lp_mode && baud16_tick && !bit_edge &&
                   !txd_in && bit_cnt == TRIG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_pend <= 1'b0;
      lp_on   <= 1'b0;
      lp_cnt  <= '0;
    end else if (!active) begin
      lp_pend <= 1'b0;
      lp_on   <= 1'b0;
      lp_cnt  <= '0;
    end else begin
      if (lp_trig)
        lp_pend <= 1'b1;
      else if (lp_tick && lp_pend)
        lp_pend <= 1'b0;
      if (lp_tick) begin
        if (lp_on) begin
          if (lp_cnt == LP_END) lp_on <= 1'b0;
          lp_cnt <= lp_cnt + LPW'(1);
        end else if (lp_pend) begin
          lp_on  <= 1'b1;
          lp_cnt <= '0;
        end
      end
    end
  end

  logic pulse_raw;
  assign pulse_raw = lp_mode ? lp_on : std_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir_tx <= 1'b0;
    else        ir_tx <= active && !loop_mode && pulse_raw;
  end

  // receive path
  logic                   dec_src, rx_s, ref_tick;
  logic [SYNC_STAGES-1:0] sync_q;
  assign dec_src  = loop_mode ? pulse_raw : ir_rx;
  assign rx_s     = sync_q[SYNC_STAGES-1];
  assign ref_tick = lp_mode ? lp_tick : baud16_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sync_q <= '0;
    else if (!active) sync_q <= '0;
    else              sync_q <= {sync_q[SYNC_STAGES-2:0], dec_src};
  end

  logic          seen, taken, accept;
  logic [HW-1:0] hold_cnt;
  assign accept = rx_s && ref_tick && seen && !taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      taken    <= 1'b0;
      hold_cnt <= '0;
    end else if (!active) begin
      seen     <= 1'b0;
      taken    <= 1'b0;
      hold_cnt <= '0;
    end else begin
      if (!rx_s) begin
        seen  <= 1'b0;
        taken <= 1'b0;
      end else if (ref_tick && !taken) begin
        if (seen) taken <= 1'b1;
        else      seen  <= 1'b1;
      end
      if (accept)
        hold_cnt <= HOLD;
      else if (baud16_tick && hold_cnt != '0)
        hold_cnt <= hold_cnt - HW'(1);
    end
  end

  assign rx_bit    = active ? (hold_cnt == '0) : wired_rxd;
  assign wired_txd = active ? 1'b1 : txd_in;
endmodule

module sir_codec_chk #(
  parameter int PULSE_TICKS    = 3,
  parameter int LP_PULSE_TICKS = 3
) (
  input logic clk,
  input logic rst_n,
  input logic uart_en,
  input logic sir_en,
  input logic lp_mode,
  input logic loop_en,
  input logic test_mode,
  input logic baud16_tick,
  input logic lp_tick,
  input logic ir_tx,
  input logic rx_bit,
  input logic rx_s
);
  logic [3:0] std_hi, lp_hi;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      std_hi <= '0;
      lp_hi  <= '0;
    end else begin
      if (!ir_tx) std_hi <= '0;
      else if (baud16_tick && std_hi != 4'hf) std_hi <= std_hi + 4'd1;
      if (!ir_tx) lp_hi <= '0;
      else if (lp_tick && lp_hi != 4'hf) lp_hi <= lp_hi + 4'd1;
    end
  end

  p_dark_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(uart_en && sir_en) |=> !ir_tx);

  p_dark_loop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && test_mode) |=> !ir_tx);

  p_std_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_tx && !lp_mode) |-> std_hi <= 4'(PULSE_TICKS));

  p_lp_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_tx && lp_mode) |-> lp_hi <= 4'(LP_PULSE_TICKS));

  p_fall_needs_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rx_bit) && uart_en && sir_en && $past(uart_en && sir_en)) |-> $past(rx_s));
endmodule

bind sir_codec sir_codec_chk #(.PULSE_TICKS(PULSE_TICKS), .LP_PULSE_TICKS(LP_PULSE_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .sir_en(sir_en), .lp_mode(lp_mode),
  .loop_en(loop_en), .test_mode(test_mode), .baud16_tick(baud16_tick), .lp_tick(lp_tick),
  .ir_tx(ir_tx), .rx_bit(rx_bit), .rx_s(rx_s));

// File: tb/sir_codec_bench.sv
module sir_codec_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uart_en = 1'b1, sir_en = 1'b1, lp_mode = 1'b0, loop_en = 1'b0, test_mode = 1'b0;
  logic txd_in = 1'b1, wired_rxd = 1'b1, ir_rx = 1'b0;
  logic baud16_tick, lp_tick;
  logic ir_tx, rx_bit, wired_txd;
  logic baud_run = 1'b1, lp_run = 1'b1;
  int   tcnt = 0, lcnt = 0;
  int   checks = 0, errors = 0;
  int   cycles = 0;
  logic rxs [1:128];

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tcnt <= (tcnt + 1) % 4;
    lcnt <= (lcnt + 1) % 3;
  end
  assign baud16_tick = baud_run && tcnt == 3;
  assign lp_tick     = lp_run && lcnt == 2;

  sir_codec u_sir_codec (
    .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .sir_en(sir_en), .lp_mode(lp_mode),
    .loop_en(loop_en), .test_mode(test_mode), .baud16_tick(baud16_tick), .lp_tick(lp_tick),
    .txd_in(txd_in), .wired_rxd(wired_rxd), .ir_rx(ir_rx),
    .ir_tx(ir_tx), .rx_bit(rx_bit), .wired_txd(wired_txd));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_in(input string req, input string what, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic align();
    @(negedge clk);
    while (tcnt != 0) @(negedge clk);
  endtask

  // one bit on txd_in; measures ir_tx and the wired line over 64 clocks
  task automatic tx_bit(input logic b, output int highs, output int first, output int rises,
                        output int txd_mis);
    logic prev = 1'b0;
    highs = 0; first = -1; rises = 0; txd_mis = 0;
    txd_in = b;
    for (int k = 1; k <= 64; k++) begin
      @(negedge clk);
      if (ir_tx) begin
        highs++;
        if (first < 0) first = k;
        if (!prev) rises++;
      end
      prev = ir_tx;
      if (wired_txd !== (sir_en && uart_en ? 1'b1 : b)) txd_mis++;
    end
  endtask

  // two bit periods with ir_rx pulses at given offsets; rx_bit recorded per clock
  task automatic rx_window(input int s1, input int l1, input int s2, input int l2);
    for (int k = 1; k <= 128; k++) begin
      @(negedge clk);
      rxs[k] = rx_bit;
      ir_rx = (k >= s1 && k < s1 + l1) || (k >= s2 && k < s2 + l2);
    end
    ir_rx = 1'b0;
  endtask

  function automatic int lows(input int a, input int b);
    int n = 0;
    for (int k = a; k <= b; k++) if (rxs[k] == 1'b0) n++;
    return n;
  endfunction

  task automatic idle();
    txd_in = 1'b1; ir_rx = 1'b0;
    repeat (140) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9", "ir_tx after reset", int'(ir_tx), 0);
    chk("R9", "rx_bit after reset", int'(rx_bit), 1);
    chk("R9", "wired_txd after reset", int'(wired_txd), 1);
  endtask

  task automatic t_std_tx();
    int h, f, r, m;
    lp_mode = 1'b0;
    align();
    tx_bit(1'b0, h, f, r, m);
    chk("R1", "pulses in zero bit", r, 1);
    chk("R1", "pulse width clocks", h, 12);
    chk_in("R1", "pulse start", f, 26, 34);
    tx_bit(1'b1, h, f, r, m);
    chk("R1", "light in one bit", h, 0);
    tx_bit(1'b0, h, f, r, m);
    chk("R1", "second zero width", h, 12);
    tx_bit(1'b0, h, f, r, m);
    chk("R1", "back-to-back zero pulses", r, 1);
    chk_in("R1", "back-to-back start", f, 26, 34);
    idle();
  endtask

  task automatic t_lp_tx();
    int h, f, r, m;
    lp_mode = 1'b1;
    align();
    tx_bit(1'b0, h, f, r, m);
    chk("R2", "lp pulses in zero bit", r, 1);
    chk("R2", "lp pulse width clocks", h, 9);
    chk_in("R2", "lp pulse start", f, 26, 38);
    tx_bit(1'b1, h, f, r, m);
    chk("R2", "lp light in one bit", h, 0);
    lp_mode = 1'b0;
    idle();
  endtask

  task automatic t_disabled();
    int h, f, r, m;
    sir_en = 1'b0;
    align();
    tx_bit(1'b0, h, f, r, m);
    chk("R3", "light with sir off", h, 0);
    chk("R3", "wired_txd follows txd_in", m, 0);
    wired_rxd = 1'b0; @(negedge clk);
    chk("R3", "rx_bit follows wired_rxd low", int'(rx_bit), 0);
    wired_rxd = 1'b1; @(negedge clk);
    chk("R3", "rx_bit follows wired_rxd high", int'(rx_bit), 1);
    align();
    rx_window(28, 12, 0, 0);
    chk("R3", "ir_rx ignored with sir off", lows(1, 128), 0);
    sir_en = 1'b1; uart_en = 1'b0;
    align();
    tx_bit(1'b0, h, f, r, m);
    chk("R3", "light with uart off", h, 0);
    chk("R3", "wired_txd passes with uart off", m, 0);
    uart_en = 1'b1;
    idle();
  endtask

  task automatic t_marking();
    int h, f, r, m;
    align();
    tx_bit(1'b0, h, f, r, m);
    chk("R4", "wired_txd held high", m, 0);
    wired_rxd = 1'b0;
    repeat (8) @(negedge clk);
    chk("R4", "wired_rxd ignored", int'(rx_bit), 1);
    wired_rxd = 1'b1;
    idle();
  endtask

  task automatic t_decode();
    align();
    rx_window(28, 12, 0, 0);
    chk("R6", "rx low after pulse", int'(rxs[44]), 0);
    chk("R6", "rx still low in hold", int'(rxs[90]), 0);
    chk("R6", "rx high after hold", int'(rxs[110]), 1);
    chk("R6", "rx high before pulse", lows(1, 30), 0);
    idle();
    align();
    rx_window(28, 12, 92, 12);
    chk("R6", "continuous low over two zero bits", lows(44, 128), 85);
    idle();
  endtask

  task automatic t_glitch();
    align();
    rx_window(28, 2, 0, 0);
    chk("R7", "short glitch rejected", lows(1, 128), 0);
    lp_mode = 1'b1;
    align();
    rx_window(28, 2, 0, 0);
    chk("R7", "short glitch rejected in lp", lows(1, 128), 0);
    lp_mode = 1'b0;
    idle();
  endtask

  task automatic t_lp_ref();
    lp_mode = 1'b1; lp_run = 1'b0;
    align();
    rx_window(28, 12, 0, 0);
    chk("R8", "no acceptance without lp_tick", lows(1, 128), 0);
    lp_run = 1'b1;
    align();
    rx_window(28, 9, 0, 0);
    chk("R8", "lp-width pulse accepted on lp_tick", int'(rxs[44]), 0);
    lp_mode = 1'b0;
    idle();
  endtask

  task automatic t_loop();
    int h, f, r, m;
    loop_en = 1'b1; test_mode = 1'b1;
    align();
    fork
      tx_bit(1'b0, h, f, r, m);
      begin
        repeat (48) @(negedge clk);
        chk("R5", "loopback decoded zero", int'(rx_bit), 0);
      end
    join
    chk("R5", "light dark in loopback", h, 0);
    idle();
    test_mode = 1'b0;
    align();
    tx_bit(1'b0, h, f, r, m);
    chk("R5", "loop_en alone keeps light", h, 12);
    loop_en = 1'b0;
    idle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_std_tx();
    t_lp_tx();
    t_disabled();
    t_marking();
    t_decode();
    t_glitch();
    t_lp_ref();
    t_loop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule